// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block watches a switching power output stage and decides, clock by clock, whether each switch may conduct and whether the whole stage must be turned off. It takes single-clock overcurrent pulses from each switch's current detector, plus an undervoltage flag, an overtemperature-warning flag, an overtemperature-error flag and an active-low device reset. All of these come from outside the clock domain, so each passes through two synchronizing flops before use. A cycle-start strobe from the modulator marks the boundaries of the switching cycles.

A single overcurrent pulse only blocks the affected switch until the end of the current switching cycle. This limits the current and does not stop the stage. If limiting recurs in too many cycles of a sliding window, the block latches an overload shutdown and holds the stage in high impedance. Only a device reset clears this latch, and only one that comes after a programmable hold-off has run out since the trip. Undervoltage and overtemperature shutdowns clear by themselves when their flag drops. The cause is shown on two active-low status outputs. While device reset is held low, both status outputs read high.

Top module: `pwr_fault_ctrl`

## Requirements
- R1: An overtemperature error, an undervoltage or a latched overload, with device reset released, drives `hiz` to 1 and `sd_n` to 0.
- R2: The status pair {`sd_n`,`warn_n`} shows one code at a time, chosen by priority: overtemperature error gives 00, else overload or undervoltage gives 01, else a temperature warning gives 10, else 11.
- R3: After reset the block shows `hiz`=0, `sd_n`=1, `warn_n`=1 and `sw_block` all zero.
- R4: An overcurrent pulse on switch i sets `sw_block[i]` from the clock its synchronized copy arrives until the next cycle-start edge, and by itself does not raise `hiz`.
- R5: An overcurrent pulse whose synchronized copy coincides with a cycle-start edge blocks its switch for the whole new cycle and counts as an event of the new cycle.
- R6: Undervoltage and overtemperature shutdowns clear, with code 11 and `hiz`=0, once their flags are removed.
- R7: While synchronized device reset is low, `sd_n` and `warn_n` are 1 and `hiz` is 1 regardless of faults, and the limiting history and the switch blocks are cleared.
- R8: At a cycle-start edge, if at least TRIP_CNT of the last WIN_CYC completed cycles contained an overcurrent pulse, the overload latch is set, and `hiz` is 1 from that edge on.
- R9: A device reset given before HOLD_CYC clocks have passed since the overload trip leaves the latch set. One given after that clears it.
- R10: Each fault input reaches the outputs exactly two clock edges after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe at each switching-cycle boundary |
| oc_pulse | input | NSW | One-clock overcurrent pulses, one per switch |
| uv_flag | input | 1 | Supply undervoltage flag |
| otw_flag | input | 1 | Junction above warning temperature |
| ote_flag | input | 1 | Junction above shutdown temperature |
| dev_rst_n | input | 1 | Active-low external device reset |
| sw_block | output | NSW | Per-switch current-limit block for the modulator |
| hiz | output | 1 | Power stage forced to high impedance |
| sd_n | output | 1 | Active-low shutdown status |
| warn_n | output | 1 | Active-low temperature warning status |

## Verification
The two functions that can fall in the same cycle are the end of a switching cycle and the arrival of a synchronized overcurrent pulse. The bench schedules the pulse so that its second synchronizer flop is full on exactly the clock in which the cycle-start strobe is sampled. It then judges the result by whether the switch stays blocked through the new cycle and by how that event later adds into the sliding-window count that trips the overload. Status codes are swept over every combination of fault flags and device reset, both with and without a latched overload, and each expected code is computed from the priority rule.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    // Status code driven on {sd_n, warn_n}
    typedef enum logic [1:0] {
        CODE_HOT  = 2'b00,
        CODE_TRIP = 2'b01,
        CODE_WARN = 2'b10,
        CODE_OK   = 2'b11
    } stat_code_t;

    // Synchronized non-overcurrent fault inputs
    typedef struct packed {
        logic ote;
        logic uv;
        logic otw;
        logic rel;   // device reset released (high = running)
    } flt_t;

    localparam int FLT_W = $bits(flt_t);

    // Priority selection of the status code
    function automatic stat_code_t pick_code(input flt_t f, input logic ovl);
        stat_code_t c;
        if (!f.rel)              c = CODE_OK;
        else if (f.ote)          c = CODE_HOT;
        else if (ovl || f.uv)    c = CODE_TRIP;
        else if (f.otw)          c = CODE_WARN;
        else                     c = CODE_OK;
        return c;
    endfunction

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= {W{RST_VAL}};
            stage2 <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pfc_limiter.sv
module pfc_limiter #(
    parameter int NSW      = 4,
    parameter int WIN_CYC  = 64,
    parameter int TRIP_CNT = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           cyc_start,
    input  logic [NSW-1:0] oc,
    output logic [NSW-1:0] sw_block,
    output logic           trip
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [NSW-1:0]     blk_q;
    logic               hit_q;
    logic [WIN_CYC-1:0] hist_q;
    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      cnt_nxt;
    logic               oc_any;

    assign oc_any  = |oc;
    assign cnt_nxt = cnt_q + CW'(hit_q) - CW'(hist_q[WIN_CYC-1]);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            blk_q  <= '0;
            hit_q  <= 1'b0;
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (cyc_start) begin
            hist_q <= {hist_q[WIN_CYC-2:0], hit_q};
            cnt_q  <= cnt_nxt;
            hit_q  <= oc_any;
            blk_q  <= oc;
        end else begin
            hit_q  <= hit_q | oc_any;
            blk_q  <= blk_q | oc;
        end
    end

    assign sw_block = blk_q | oc;
    assign trip     = run && cyc_start && (cnt_nxt >= CW'(TRIP_CNT));

    // R4
    blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (oc != '0 && run && !cyc_start) |=> ((blk_q & $past(oc)) == $past(oc)));

    // R8
    win_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(WIN_CYC));

endmodule

// File: rtl/pfc_ovl_latch.sv
module pfc_ovl_latch #(
    parameter int HOLD_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic rel,
    output logic ovl
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic          ovl_q;
    logic [HW-1:0] hold_q;
    logic          hold_done;

    assign hold_done = (hold_q == HW'(HOLD_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            ovl_q  <= 1'b0;
            hold_q <= '0;
        end else if (!ovl_q) begin
            if (trip) begin
                ovl_q  <= 1'b1;
                hold_q <= '0;
            end
        end else if (!rel && hold_done) begin
            ovl_q  <= 1'b0;
        end else if (!hold_done) begin
            hold_q <= hold_q + HW'(1);
        end
    end

    assign ovl = ovl_q;

    // R9
    early_rel_chk: assert property (@(posedge clk) disable iff (rst)
        (ovl_q && !hold_done) |=> ovl_q);

endmodule

// File: rtl/pfc_status.sv
module pfc_status
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  flt_t flt,
    input  logic ovl,
    output logic sd_n,
    output logic warn_n
);
    stat_code_t code;

    assign code   = pick_code(flt, ovl);
    assign sd_n   = code[1];
    assign warn_n = code[0];

    // R7
    rst_force_chk: assert property (@(posedge clk) disable iff (rst)
        !flt.rel |-> (sd_n && warn_n));

    // R2
    hot_code_chk: assert property (@(posedge clk) disable iff (rst)
        (flt.rel && flt.ote) |-> (!sd_n && !warn_n));

endmodule

// File: rtl/pwr_fault_ctrl.sv
module pwr_fault_ctrl
    import pfc_pkg::*;
#(
    parameter int NSW      = 4,
    parameter int WIN_CYC  = 64,
    parameter int TRIP_CNT = 8,
    parameter int HOLD_CYC = 100_000_000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cyc_start,
    input  logic [NSW-1:0] oc_pulse,
    input  logic           uv_flag,
    input  logic           otw_flag,
    input  logic           ote_flag,
    input  logic           dev_rst_n,
    output logic [NSW-1:0] sw_block,
    output logic           hiz,
    output logic           sd_n,
    output logic           warn_n
);
    flt_t           flt_raw;
    flt_t           flt_s;
    logic [NSW-1:0] oc_s;
    logic           trip;
    logic           ovl;

    assign flt_raw = '{ote: ote_flag, uv: uv_flag, otw: otw_flag, rel: dev_rst_n};

    // fault flags: reset to idle, device reset released
    pfc_sync #(.W(FLT_W - 1), .RST_VAL(1'b0)) u_sync_flt (
        .clk (clk),
        .rst (rst),
        .d   ({flt_raw.ote, flt_raw.uv, flt_raw.otw}),
        .q   ({flt_s.ote, flt_s.uv, flt_s.otw})
    );

    pfc_sync #(.W(1), .RST_VAL(1'b1)) u_sync_rel (
        .clk (clk),
        .rst (rst),
        .d   (flt_raw.rel),
        .q   (flt_s.rel)
    );

    pfc_sync #(.W(NSW), .RST_VAL(1'b0)) u_sync_oc (
        .clk (clk),
        .rst (rst),
        .d   (oc_pulse),
        .q   (oc_s)
    );

    pfc_limiter #(
        .NSW      (NSW),
        .WIN_CYC  (WIN_CYC),
        .TRIP_CNT (TRIP_CNT)
    ) u_limiter (
        .clk       (clk),
        .rst       (rst),
        .run       (flt_s.rel),
        .cyc_start (cyc_start),
        .oc        (oc_s),
        .sw_block  (sw_block),
        .trip      (trip)
    );

    pfc_ovl_latch #(.HOLD_CYC(HOLD_CYC)) u_ovl (
        .clk  (clk),
        .rst  (rst),
        .trip (trip),
        .rel  (flt_s.rel),
        .ovl  (ovl)
    );

    pfc_status u_status (
        .clk    (clk),
        .rst    (rst),
        .flt    (flt_s),
        .ovl    (ovl),
        .sd_n   (sd_n),
        .warn_n (warn_n)
    );

    assign hiz = !flt_s.rel || flt_s.ote || flt_s.uv || ovl;

    // R1
    stage_off_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_s.rel && (flt_s.ote || flt_s.uv || ovl)) |-> (hiz && !sd_n));

    // R8
    trip_off_chk: assert property (@(posedge clk) disable iff (rst)
        trip |=> hiz);

endmodule

// File: tb/pwr_fault_ctrl_test.sv
module pwr_fault_ctrl_test;
    localparam int PERIOD = 10;
    localparam int NSW    = 2;
    localparam int WIN    = 8;
    localparam int TRIP   = 3;
    localparam int HOLD   = 60;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cyc_start = 1'b0;
    logic [NSW-1:0] oc_pulse = '0;
    logic           uv_flag = 1'b0;
    logic           otw_flag = 1'b0;
    logic           ote_flag = 1'b0;
    logic           dev_rst_n = 1'b1;
    logic [NSW-1:0] sw_block;
    logic           hiz;
    logic           sd_n;
    logic           warn_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    pwr_fault_ctrl #(
        .NSW(NSW), .WIN_CYC(WIN), .TRIP_CNT(TRIP), .HOLD_CYC(HOLD)
    ) uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .oc_pulse(oc_pulse),
        .uv_flag(uv_flag), .otw_flag(otw_flag), .ote_flag(ote_flag),
        .dev_rst_n(dev_rst_n), .sw_block(sw_block), .hiz(hiz),
        .sd_n(sd_n), .warn_n(warn_n)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // drive at negedge, pass one rising edge, return at next negedge
    task automatic tick(input logic cs, input logic [NSW-1:0] oc);
        cyc_start = cs;
        oc_pulse  = oc;
        @(posedge clk);
        @(negedge clk);
        cyc_start = 1'b0;
        oc_pulse  = '0;
    endtask

    // one switching cycle: pulse early, sample blocks, then boundary edge
    task automatic cyc(input logic [NSW-1:0] oc, output logic [NSW-1:0] seen);
        tick(1'b0, oc);
        tick(1'b0, '0);
        tick(1'b0, '0);
        seen = sw_block;
        tick(1'b1, '0);
    endtask

    function automatic logic [1:0] exp_code(input logic ote, input logic uv,
                                            input logic otw, input logic rel,
                                            input logic ovl);
        if (!rel)            return 2'b11;
        else if (ote)        return 2'b00;
        else if (ovl || uv)  return 2'b01;
        else if (otw)        return 2'b10;
        else                 return 2'b11;
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [NSW-1:0] seen;
        logic [1:0]     prev_code;
        logic           prev_hiz;
        @(negedge clk);
        for (int k = 0; k < 4; k++) tick(1'b0, '0);
        rst = 1'b0;
        tick(1'b0, '0);

        // R3 reset state
        chk({7'd0, hiz}, 8'd0, "R3 hiz");
        chk({6'd0, sd_n, warn_n}, 8'd3, "R3 code");
        chk({6'd0, sw_block}, 8'd0, "R3 sw_block");

        // R1 R2 R7 R10: full sweep of flag combinations
        prev_code = 2'b11;
        prev_hiz  = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic [1:0] ec;
            logic       eh;
            ote_flag  = i[0];
            uv_flag   = i[1];
            otw_flag  = i[2];
            dev_rst_n = ~i[3];
            ec = exp_code(i[0], i[1], i[2], ~i[3], 1'b0);
            eh = i[3] | i[0] | i[1];
            tick(1'b0, '0);
            chk({6'd0, sd_n, warn_n}, {6'd0, prev_code}, "R10 code one edge");
            chk({7'd0, hiz}, {7'd0, prev_hiz}, "R10 hiz one edge");
            tick(1'b0, '0);
            chk({6'd0, sd_n, warn_n}, {6'd0, ec}, i[3] ? "R7 code" : "R2 code");
            chk({7'd0, hiz}, {7'd0, eh}, i[3] ? "R7 hiz" : "R1 hiz");
            prev_code = ec;
            prev_hiz  = eh;
        end
        ote_flag = 1'b1; uv_flag = 1'b1; otw_flag = 1'b0; dev_rst_n = 1'b1;
        tick(1'b0, '0); tick(1'b0, '0);
        chk({6'd0, sd_n, warn_n}, 8'd0, "R2 ote over uv");
        ote_flag = 1'b0; uv_flag = 1'b0;
        tick(1'b0, '0); tick(1'b0, '0);
        // R6 self recovery
        chk({6'd0, sd_n, warn_n}, 8'd3, "R6 code");
        chk({7'd0, hiz}, 8'd0, "R6 hiz");

        // R4 single limit event
        cyc(2'b01, seen);
        chk({6'd0, seen}, 8'd1, "R4 block held");
        chk({7'd0, hiz}, 8'd0, "R4 no shutdown");
        chk({6'd0, sw_block}, 8'd0, "R4 block cleared at boundary");

        // R5 pulse arriving together with the boundary
        tick(1'b0, 2'b10);
        tick(1'b0, '0);
        tick(1'b1, '0);
        chk({6'd0, sw_block}, 8'd2, "R5 block in new cycle");
        tick(1'b0, '0);
        chk({6'd0, sw_block}, 8'd2, "R5 block persists");
        tick(1'b0, '0);
        tick(1'b1, '0);
        chk({6'd0, sw_block}, 8'd0, "R5 block ends");
        chk({7'd0, hiz}, 8'd0, "R5 two events no trip");

        // R7 device reset clears history
        dev_rst_n = 1'b0;
        for (int k = 0; k < 3; k++) tick(1'b0, '0);
        dev_rst_n = 1'b1;
        tick(1'b0, '0); tick(1'b0, '0);
        chk({7'd0, hiz}, 8'd0, "R7 running again");

        // R8 sliding window
        cyc(2'b01, seen);
        cyc(2'b10, seen);
        for (int k = 0; k < 6; k++) cyc('0, seen);
        cyc(2'b01, seen);
        chk({7'd0, hiz}, 8'd0, "R8 oldest events aged out");
        cyc(2'b01, seen);
        chk({7'd0, hiz}, 8'd0, "R8 two in window");
        cyc(2'b11, seen);
        chk({7'd0, hiz}, 8'd1, "R8 trip at boundary");
        chk({6'd0, sd_n, warn_n}, 8'd1, "R8 overload code");
        for (int k = 0; k < 2; k++) cyc('0, seen);
        chk({7'd0, hiz}, 8'd1, "R8 latched without events");

        // R2 sweep under latched overload
        for (int i = 0; i < 8; i++) begin
            ote_flag = i[0];
            uv_flag  = i[1];
            otw_flag = i[2];
            tick(1'b0, '0); tick(1'b0, '0);
            chk({6'd0, sd_n, warn_n}, {6'd0, exp_code(i[0], i[1], i[2], 1'b1, 1'b1)},
                "R2 latched code");
        end
        ote_flag = 1'b0; uv_flag = 1'b0; otw_flag = 1'b0;
        tick(1'b0, '0); tick(1'b0, '0);

        // R9 early reset is ignored
        dev_rst_n = 1'b0;
        for (int k = 0; k < 3; k++) tick(1'b0, '0);
        chk({6'd0, sd_n, warn_n}, 8'd3, "R7 forced high in latch");
        dev_rst_n = 1'b1;
        tick(1'b0, '0); tick(1'b0, '0);
        chk({6'd0, sd_n, warn_n}, 8'd1, "R9 early reset ignored");
        chk({7'd0, hiz}, 8'd1, "R9 still off");

        // R9 late reset releases
        for (int k = 0; k < HOLD; k++) tick(1'b0, '0);
        dev_rst_n = 1'b0;
        for (int k = 0; k < 3; k++) tick(1'b0, '0);
        dev_rst_n = 1'b1;
        tick(1'b0, '0); tick(1'b0, '0);
        chk({6'd0, sd_n, warn_n}, 8'd3, "R9 released code");
        chk({7'd0, hiz}, 8'd0, "R9 released hiz");
        cyc(2'b01, seen);
        chk({7'd0, hiz}, 8'd0, "R7 history cleared by reset");

        summary();
        $finish;
    end
endmodule